// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block runs one complete register transaction on an I2C bus: a single-byte write into a device register, or a single-byte read from one. A client presents a request on one cycle. The request carries a read/write select, a 7-bit device address, an 8-bit register index and, for writes, one data byte.

The sequencer then walks a fixed list of byte-level steps. For each step it presents a command code, start and stop qualifiers, a byte to send and the acknowledge bit to return. It moves to the next step only when a byte-level engine below it reports completion.

A read first addresses the device for writing so that the register index can be sent. It then uses a repeated start to address the device again for reading, takes one byte, and ends with a stop. When a device-address byte is not acknowledged, the sequencer issues a stop, sets a sticky error flag and ends the transaction. When the engine below reports a lost arbitration, the sequencer abandons the transaction at once and sets a sticky status flag.

Top module: `regxfer_seq`

## Requirements
- R1: While `rst_n` is low and after its release, with no request given, `busy`, `done`, `err_nack`, `arb_lost`, `bc_sta`, `bc_sto` and `bc_mack` are 0 and `bc_cmd` is NOP (code 0).
- R2: A write request (`req_rd`=0) produces exactly four byte steps, in this order:
  - WRITE (code 3) with `bc_sta`=1 and byte {dev,0};
  - WRITE with the register index;
  - WRITE with the data byte;
  - STOP (code 2) with `bc_sto`=1 and byte 0.
- R3: A read request (`req_rd`=1) produces exactly five byte steps, in this order:
  - WRITE with `bc_sta`=1 and byte {dev,0};
  - WRITE with the register index;
  - WRITE with `bc_sta`=1 and byte {dev,1}, which differs from the first address byte only in bit 0;
  - READ (code 4) with byte 0;
  - STOP with `bc_sto`=1.
- R4: `bc_sta` is 1 only during device-address steps. `bc_sto` is 1 only during STOP steps. READ appears only in the data-read step. Code 1 is never issued.
- R5: While busy, the command outputs hold their values until `bc_done` or `bc_arb` is seen high at a clock edge. The next step's command appears on the following cycle.
- R6: If `bc_nack`=1 when a device-address step completes, the next step is a STOP with `bc_sto`=1. `err_nack` rises on that same edge and stays 1 after the transaction until the next request is accepted, which clears it.
- R7: The READ step drives `bc_mack`=1 (no acknowledge, last byte). On completion of that step, `bc_rxd` is stored into `rdata`, which holds it afterwards.
- R8: `busy` is 1 from the cycle after a request is accepted until the transaction ends. `done` is then 1 for exactly one cycle, and during that cycle `busy` is already 0.
- R9: `req_valid` is ignored while `busy` is 1. The step sequence in progress is unchanged.
- R10: `bc_arb`=1 at a clock edge while busy returns the sequencer to idle with no further steps. It sets `arb_lost`, which is sticky until the next accepted request, and pulses `done`.
- R11: `bc_nack`=1 on completion of a register-index or data step has no effect; the sequence continues as in R2 or R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_rd | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | 7 | Device address |
| req_reg | input | 8 | Register index |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last byte read |
| err_nack | output | 1 | Sticky: device address not acknowledged |
| arb_lost | output | 1 | Sticky: transaction aborted by lost arbitration |
| bc_cmd | output | 3 | Byte command: 0 NOP, 1 START, 2 STOP, 3 WRITE, 4 READ |
| bc_sta | output | 1 | Start qualifier |
| bc_sto | output | 1 | Stop qualifier |
| bc_txd | output | 8 | Byte to transmit |
| bc_mack | output | 1 | Acknowledge bit the master returns on a read (1 = NACK) |
| bc_done | input | 1 | Byte engine finished the current step |
| bc_nack | input | 1 | Slave did not acknowledge, valid with `bc_done` |
| bc_rxd | input | 8 | Received byte, valid with `bc_done` |
| bc_arb | input | 1 | Byte engine lost arbitration |

## Verification
The properties assume a well-behaved byte engine. `bc_done` is a single-cycle pulse that comes only while a command is presented and at least one cycle after that command appears. `bc_nack` and `bc_rxd` are meaningful only alongside it, and `bc_arb` is raised only during a transaction. The bench's responder keeps to this contract: it waits a fixed latency after each new command, then raises either the completion or the arbitration pulse for one cycle and never both. It injects a not-acknowledge or a lost arbitration only at a chosen step index.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  // Byte-engine command codes; values are visible on the bc_cmd port.
  typedef enum logic [2:0] {
    BC_NOP   = 3'd0,
    BC_START = 3'd1,
    BC_STOP  = 3'd2,
    BC_WRITE = 3'd3,
    BC_READ  = 3'd4
  } bc_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WADDR,
    S_WREG,
    S_WDATA,
    S_WSTOP,
    S_RADDR0,
    S_RREG,
    S_RADDR1,
    S_RDATA,
    S_RSTOP,
    S_ESTOP
  } seq_state_e;

endpackage

// File: rtl/regxfer_fsm.sv
module regxfer_fsm
  import regxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_rd,
  input  logic       bc_done,
  input  logic       bc_nack,
  input  logic       bc_arb,
  output seq_state_e state,
  output logic       accept,
  output logic       finish,
  output logic       capture,
  output logic       nack_hit,
  output logic       arb_hit
);

  seq_state_e state_nx;
  logic       active;
  logic       is_addr;

  assign active  = (state != S_IDLE);
  assign is_addr = (state == S_WADDR) || (state == S_RADDR0) || (state == S_RADDR1);

  always_comb begin
    state_nx = state;
    if (!active) begin
      if (req_valid) state_nx = req_rd ? S_RADDR0 : S_WADDR;
    end else if (bc_arb) begin
      state_nx = S_IDLE;
    end else if (bc_done) begin
      if (is_addr && bc_nack) begin
        state_nx = S_ESTOP;
      end else begin
        unique case (state)
          S_WADDR:  state_nx = S_WREG;
          S_WREG:   state_nx = S_WDATA;
          S_WDATA:  state_nx = S_WSTOP;
          S_RADDR0: state_nx = S_RREG;
          S_RREG:   state_nx = S_RADDR1;
          S_RADDR1: state_nx = S_RDATA;
          S_RDATA:  state_nx = S_RSTOP;
          default:  state_nx = S_IDLE;   // stop states
        endcase
      end
    end
  end

  assign accept   = !active && req_valid;
  assign finish   = active && (state_nx == S_IDLE);
  assign capture  = (state == S_RDATA) && bc_done && !bc_arb;
  assign nack_hit = (state_nx == S_ESTOP) && (state != S_ESTOP);
  assign arb_hit  = active && bc_arb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/regxfer_stat.sv
module regxfer_stat #(
  parameter int DEV_W  = 7,
  parameter int BYTE_W = DEV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  logic              capture,
  input  logic              nack_hit,
  input  logic              arb_hit,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BYTE_W-1:0] req_reg,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] bc_rxd,
  output logic [DEV_W-1:0]  lat_dev,
  output logic [BYTE_W-1:0] lat_reg,
  output logic [BYTE_W-1:0] lat_wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              err_nack,
  output logic              arb_lost,
  output logic              done
);

  // Request fields, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_dev   <= '0;
      lat_reg   <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_dev   <= req_dev;
      lat_reg   <= req_reg;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= bc_rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_nack <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      if (accept)        err_nack <= 1'b0;
      else if (nack_hit) err_nack <= 1'b1;
      if (accept)        arb_lost <= 1'b0;
      else if (arb_hit)  arb_lost <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= finish;
  end

endmodule

// File: rtl/regxfer_cmd.sv
module regxfer_cmd
  import regxfer_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int BYTE_W = DEV_W + 1
) (
  input  seq_state_e        state,
  input  logic [DEV_W-1:0]  lat_dev,
  input  logic [BYTE_W-1:0] lat_reg,
  input  logic [BYTE_W-1:0] lat_wdata,
  output bc_cmd_e           cmd,
  output logic              sta,
  output logic              sto,
  output logic [BYTE_W-1:0] txd,
  output logic              mack
);

  always_comb begin
    cmd  = BC_NOP;
    sta  = 1'b0;
    sto  = 1'b0;
    txd  = '0;
    mack = 1'b0;
    unique case (state)
      S_WADDR, S_RADDR0: begin
        cmd = BC_WRITE;
        sta = 1'b1;
        txd = {lat_dev, 1'b0};
      end
      S_RADDR1: begin
        cmd = BC_WRITE;
        sta = 1'b1;
        txd = {lat_dev, 1'b1};
      end
      S_WREG, S_RREG: begin
        cmd = BC_WRITE;
        txd = lat_reg;
      end
      S_WDATA: begin
        cmd = BC_WRITE;
        txd = lat_wdata;
      end
      S_RDATA: begin
        cmd  = BC_READ;
        mack = 1'b1;                 // last byte: answer with NACK
      end
      S_WSTOP, S_RSTOP, S_ESTOP: begin
        cmd = BC_STOP;
        sto = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int DEV_W = 7,
  localparam int BYTE_W = DEV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rd,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BYTE_W-1:0] req_reg,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              err_nack,
  output logic              arb_lost,
  output logic [2:0]        bc_cmd,
  output logic              bc_sta,
  output logic              bc_sto,
  output logic [BYTE_W-1:0] bc_txd,
  output logic              bc_mack,
  input  logic              bc_done,
  input  logic              bc_nack,
  input  logic [BYTE_W-1:0] bc_rxd,
  input  logic              bc_arb
);

  seq_state_e        state;
  bc_cmd_e           cmd;
  logic              accept, finish, capture, nack_hit, arb_hit;
  logic [DEV_W-1:0]  lat_dev;
  logic [BYTE_W-1:0] lat_reg, lat_wdata;

  regxfer_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_rd   (req_rd),
    .bc_done  (bc_done),
    .bc_nack  (bc_nack),
    .bc_arb   (bc_arb),
    .state    (state),
    .accept   (accept),
    .finish   (finish),
    .capture  (capture),
    .nack_hit (nack_hit),
    .arb_hit  (arb_hit)
  );

  regxfer_stat #(.DEV_W(DEV_W), .BYTE_W(BYTE_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .finish   (finish),
    .capture  (capture),
    .nack_hit (nack_hit),
    .arb_hit  (arb_hit),
    .req_dev  (req_dev),
    .req_reg  (req_reg),
    .req_wdata(req_wdata),
    .bc_rxd   (bc_rxd),
    .lat_dev  (lat_dev),
    .lat_reg  (lat_reg),
    .lat_wdata(lat_wdata),
    .rdata    (rdata),
    .err_nack (err_nack),
    .arb_lost (arb_lost),
    .done     (done)
  );

  regxfer_cmd #(.DEV_W(DEV_W), .BYTE_W(BYTE_W)) u_cmd (
    .state    (state),
    .lat_dev  (lat_dev),
    .lat_reg  (lat_reg),
    .lat_wdata(lat_wdata),
    .cmd      (cmd),
    .sta      (bc_sta),
    .sto      (bc_sto),
    .txd      (bc_txd),
    .mack     (bc_mack)
  );

  assign bc_cmd = cmd;
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err_nack,
  input logic              arb_lost,
  input logic [2:0]        bc_cmd,
  input logic              bc_sta,
  input logic              bc_sto,
  input logic [BYTE_W-1:0] bc_txd,
  input logic              bc_mack,
  input logic              bc_done,
  input logic              bc_nack,
  input logic              bc_arb
);

  // R4
  sta_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_sta |-> (bc_cmd == 3'd3));

  // R4
  sto_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_sto |-> (bc_cmd == 3'd2));

  // R5
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bc_done && !bc_arb) |=> ($stable(bc_cmd) && $stable(bc_txd) && $stable(bc_sta)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nack) |-> ($past(bc_done && bc_nack) && bc_sto));

  // R7
  read_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_cmd == 3'd4) |-> bc_mack);

  // R10
  arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(bc_arb) && done && !busy));

endmodule

bind regxfer_seq regxfer_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err_nack(err_nack),
  .arb_lost(arb_lost),
  .bc_cmd  (bc_cmd),
  .bc_sta  (bc_sta),
  .bc_sto  (bc_sto),
  .bc_txd  (bc_txd),
  .bc_mack (bc_mack),
  .bc_done (bc_done),
  .bc_nack (bc_nack),
  .bc_arb  (bc_arb)
);

// File: tb/sim_regxfer_seq.sv
module sim_regxfer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int NVEC       = 9;

  typedef struct packed {
    logic       rd;
    logic [6:0] dev;
    logic [7:0] rg;
    logic [7:0] wd;
    logic [7:0] rx;
    logic [3:0] nk;   // step index answered with NACK, 15 = none
    logic [3:0] ab;   // step index that loses arbitration, 15 = none
    logic       xe;   // expected err_nack
    logic       xa;   // expected arb_lost
  } vec_t;

  localparam vec_t VT [NVEC] = '{
    '{1'b0, 7'h50, 8'h12, 8'hA5, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0},
    '{1'b1, 7'h3C, 8'h07, 8'h00, 8'h5A, 4'hF, 4'hF, 1'b0, 1'b0},
    '{1'b0, 7'h21, 8'h40, 8'h33, 8'h00, 4'h0, 4'hF, 1'b1, 1'b0},
    '{1'b1, 7'h22, 8'h41, 8'h00, 8'h77, 4'h0, 4'hF, 1'b1, 1'b0},
    '{1'b1, 7'h23, 8'h42, 8'h00, 8'h88, 4'h2, 4'hF, 1'b1, 1'b0},
    '{1'b0, 7'h24, 8'h43, 8'hC3, 8'h00, 4'h2, 4'hF, 1'b0, 1'b0},
    '{1'b1, 7'h25, 8'h44, 8'h00, 8'h99, 4'hF, 4'h1, 1'b0, 1'b1},
    '{1'b0, 7'h26, 8'h45, 8'h5C, 8'h00, 4'hF, 4'h3, 1'b0, 1'b1},
    '{1'b1, 7'h7F, 8'hFF, 8'h00, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0}
  };

  logic       clk, rst_n;
  logic       req_valid, req_rd;
  logic [6:0] req_dev;
  logic [7:0] req_reg, req_wdata;
  logic       busy, done, err_nack, arb_lost;
  logic [7:0] rdata, bc_txd, bc_rxd;
  logic [2:0] bc_cmd;
  logic       bc_sta, bc_sto, bc_mack;
  logic       bc_done, bc_nack, bc_arb;

  regxfer_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_rd(req_rd), .req_dev(req_dev),
    .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .err_nack(err_nack), .arb_lost(arb_lost),
    .bc_cmd(bc_cmd), .bc_sta(bc_sta), .bc_sto(bc_sto),
    .bc_txd(bc_txd), .bc_mack(bc_mack),
    .bc_done(bc_done), .bc_nack(bc_nack), .bc_rxd(bc_rxd), .bc_arb(bc_arb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit reported = 0;

  // Step record: {cmd, sta, sto, mack, byte}
  logic [13:0] lg  [16];
  logic [13:0] ex  [16];
  int          nlog = 0;
  int          nexp = 0;
  logic [3:0]  nk_i = 4'hF;
  logic [3:0]  ab_i = 4'hF;
  logic [7:0]  rx_i = 8'h00;
  int          rsp_idx;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Byte-engine responder: completes each new step after LAT cycles.
  initial begin
    bc_done = 1'b0; bc_nack = 1'b0; bc_arb = 1'b0; bc_rxd = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && bc_cmd != 3'd0) begin
        rsp_idx = nlog;
        if (nlog < 16) lg[nlog] = {bc_cmd, bc_sta, bc_sto, bc_mack, bc_txd};
        nlog++;
        repeat (LAT) @(negedge clk);
        if (rsp_idx == int'(ab_i)) begin
          bc_arb = 1'b1;
        end else begin
          bc_done = 1'b1;
          bc_nack = (rsp_idx == int'(nk_i));
          bc_rxd  = rx_i;
        end
        @(negedge clk);
        bc_done = 1'b0; bc_arb = 1'b0; bc_nack = 1'b0;
      end
    end
  end

  // Expected step list from R2/R3, cut by R6 (address NACK) or R10 (arbitration).
  task automatic build_exp(input vec_t v);
    logic [13:0] full [6];
    bit          isadr [6];
    int          len;
    if (v.rd) begin
      full[0] = {3'd3, 1'b1, 1'b0, 1'b0, v.dev, 1'b0}; isadr[0] = 1;
      full[1] = {3'd3, 1'b0, 1'b0, 1'b0, v.rg};        isadr[1] = 0;
      full[2] = {3'd3, 1'b1, 1'b0, 1'b0, v.dev, 1'b1}; isadr[2] = 1;
      full[3] = {3'd4, 1'b0, 1'b0, 1'b1, 8'h00};       isadr[3] = 0;
      full[4] = {3'd2, 1'b0, 1'b1, 1'b0, 8'h00};       isadr[4] = 0;
      len = 5;
    end else begin
      full[0] = {3'd3, 1'b1, 1'b0, 1'b0, v.dev, 1'b0}; isadr[0] = 1;
      full[1] = {3'd3, 1'b0, 1'b0, 1'b0, v.rg};        isadr[1] = 0;
      full[2] = {3'd3, 1'b0, 1'b0, 1'b0, v.wd};        isadr[2] = 0;
      full[3] = {3'd2, 1'b0, 1'b1, 1'b0, 8'h00};       isadr[3] = 0;
      len = 4;
    end
    nexp = 0;
    for (int i = 0; i < len; i++) begin
      ex[nexp] = full[i];
      nexp++;
      if (i == int'(v.ab)) break;
      if (i == int'(v.nk) && isadr[i]) begin
        ex[nexp] = {3'd2, 1'b0, 1'b1, 1'b0, 8'h00};
        nexp++;
        break;
      end
    end
  endtask

  task automatic do_xfer(input vec_t v, input bit intr);
    bit    got;
    bit    same;
    string tag;
    build_exp(v);
    if (v.ab != 4'hF)                                         tag = "R10";
    else if (v.nk != 4'hF && (v.nk == 4'h0 || (v.rd && v.nk == 4'h2))) tag = "R6";
    else if (v.nk != 4'hF)                                    tag = "R11";
    else if (intr)                                            tag = "R9";
    else if (v.rd)                                            tag = "R3";
    else                                                      tag = "R2";
    nk_i = v.nk; ab_i = v.ab; rx_i = v.rx;
    @(negedge clk);
    nlog = 0;
    req_valid = 1'b1; req_rd = v.rd; req_dev = v.dev; req_reg = v.rg; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    chk(!err_nack && !arb_lost, "R6 R10 flags cleared on accept", {err_nack, arb_lost}, 0);
    got = 0;
    for (int c = 0; c < 400 && !got; c++) begin
      if (intr && c == 2) begin
        req_valid = 1'b1; req_rd = ~v.rd; req_dev = 7'h11; req_reg = 8'h99; req_wdata = 8'h66;
      end
      if (intr && c == 4) req_valid = 1'b0;
      @(negedge clk);
      if (done) got = 1;
    end
    chk(got, "R8 done pulse seen", got, 1);
    chk(!busy, "R8 busy low in done cycle", busy, 0);
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", done, 0);
    same = (nlog == nexp);
    for (int i = 0; i < nexp && i < 16; i++) if (lg[i] !== ex[i]) same = 0;
    // step list also covers the qualifier placement of R4 and step gating of R5
    chk(same, $sformatf("%s R4 R5 step sequence (count/last step)", tag),
        {nlog[7:0], (nlog > 0 ? lg[(nlog-1) % 16] : 14'h0)},
        {nexp[7:0], ex[nexp-1]});
    chk(err_nack == v.xe, $sformatf("%s err_nack", tag), err_nack, v.xe);
    chk(arb_lost == v.xa, $sformatf("%s arb_lost", tag), arb_lost, v.xa);
    if (v.rd && !v.xe && !v.xa)
      chk(rdata == v.rx, "R7 read byte captured", rdata, v.rx);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    req_valid = 1'b0; req_rd = 1'b0; req_dev = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(!busy && !done && !err_nack && !arb_lost && bc_cmd == 3'd0 && !bc_sta && !bc_sto && !bc_mack,
        "R1 reset outputs", {busy, done, err_nack, arb_lost, bc_cmd, bc_sta, bc_sto, bc_mack}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && bc_cmd == 3'd0, "R1 idle after release", {busy, done, bc_cmd}, 0);

    for (int k = 0; k < NVEC; k++) begin
      do_xfer(VT[k], 1'b0);
      if (k == 2) begin
        repeat (5) @(negedge clk);
        chk(err_nack == 1'b1, "R6 err_nack sticky while idle", err_nack, 1);
      end
      if (k == 6) begin
        repeat (5) @(negedge clk);
        chk(arb_lost == 1'b1, "R10 arb_lost sticky while idle", arb_lost, 1);
      end
    end

    // R9: a second request during a write is ignored
    v = '{1'b0, 7'h0A, 8'h5E, 8'h3F, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0};
    do_xfer(v, 1'b1);
    repeat (2 * LAT + 4) @(negedge clk);
    chk(!busy && bc_cmd == 3'd0, "R9 no transaction started by ignored request", {busy, bc_cmd}, 0);

    // R7: rdata holds after a following write
    v = '{1'b1, 7'h12, 8'h34, 8'h00, 8'hC7, 4'hF, 4'hF, 1'b0, 1'b0};
    do_xfer(v, 1'b0);
    v = '{1'b0, 7'h13, 8'h35, 8'h01, 8'h00, 4'hF, 4'hF, 1'b0, 1'b0};
    do_xfer(v, 1'b0);
    chk(rdata == 8'hC7, "R7 rdata held across write", rdata, 8'hC7);

    finish_run();
  end

endmodule